// File: doc/BRIEF.md
# Refresh Interval Timer with Pending-Refresh Queue

This block paces DRAM refresh. A free-running up-counter, clocked by the peripheral bus clock, is compared every cycle against a compare value set by software. When the count reaches that value the timer expires: the counter starts again from zero, a sticky timeout flag is raised, and that flag serves directly as the interrupt line.

When the refresh-enable control is set, each expiry also adds one owed refresh to a small bounded tally. Owed refreshes are handed one at a time to the DRAM command sequencer through a request/acknowledge handshake. A request is raised only while the memory bus reports idle. Every request drives both chip-select lines together. If an expiry arrives while the tally is already full, that refresh is dropped and a sticky overflow flag is raised.

With refresh-enable cleared, the block is a plain periodic interrupt timer. Software clears each sticky flag with a one-cycle clear pulse.

Top module: `rfsh_interval_timer`

## Requirements
- R1: After reset, curCount is 0, timeoutIrq and queueOverflow are 0, pendingCnt is 0 and refreshReq is 0.
- R2: While timerEn is 1, curCount rises by exactly one on each clock edge that is not an expiry. While timerEn is 0, curCount is held at 0 from the next edge on, and no expiry occurs.
- R3: An expiry is a cycle with timerEn at 1 and curCount equal to cmpValue. On the following edge curCount becomes 0, so the timer repeats every cmpValue+1 cycles.
- R4: Each expiry sets timeoutIrq, which stays at 1 until a cycle with clrTimeout at 1 clears it. If a clear and an expiry fall in the same cycle, timeoutIrq stays at 1.
- R5: With refreshEn at 0, expiries leave pendingCnt unchanged. The only effect of an expiry is then on timeoutIrq.
- R6: pendingCnt ranges from 0 to QUEUE_DEPTH (8 by default). An expiry with refreshEn at 1 adds one to it, and an accepted acknowledge removes one. When both happen in the same cycle, pendingCnt is unchanged.
- R7: An expiry with refreshEn at 1, while pendingCnt equals QUEUE_DEPTH and no acknowledge is accepted, is discarded and sets queueOverflow. queueOverflow is sticky and is cleared by clrOverflow, with a same-cycle set winning over the clear.
- R8: refreshReq rises on the edge after a cycle in which it is 0, pendingCnt is non-zero and busIdle is 1. Once high, it stays high until the sequencer acknowledges. It falls on the edge after a cycle in which both refreshReq and refreshAck are 1, and that cycle counts as an accepted acknowledge.
- R9: refreshCs drives all NUM_CS bits to 1 while refreshReq is 1 and all bits to 0 otherwise.
- R10: Clearing timerEn leaves pendingCnt unchanged, and refreshes still owed keep being requested and issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral bus clock |
| rstN | input | 1 | Active-low asynchronous reset |
| timerEn | input | 1 | Counter run enable |
| refreshEn | input | 1 | Queue a refresh on each expiry |
| cmpValue | input | CNT_W | Expiry compare value |
| clrTimeout | input | 1 | Clear pulse for the timeout flag |
| clrOverflow | input | 1 | Clear pulse for the overflow flag |
| busIdle | input | 1 | Memory bus has no transaction in flight |
| refreshAck | input | 1 | Sequencer accepts the current refresh |
| curCount | output | CNT_W | Current counter value |
| timeoutIrq | output | 1 | Sticky timeout flag / interrupt |
| queueOverflow | output | 1 | Sticky dropped-refresh flag |
| pendingCnt | output | clog2(QUEUE_DEPTH+1) | Refreshes still owed |
| refreshReq | output | 1 | Refresh request to the sequencer |
| refreshCs | output | NUM_CS | Chip selects for the requested refresh |

## Verification
The bench builds the block with its default parameters: a 16-bit counter, a tally depth of eight and two chip selects. The bench works with compare values of 0, 1 and 4. These give expiry periods of one to five cycles, so the full tally, the dropped ninth refresh, an expiry coinciding with an acknowledge, and a clear coinciding with an expiry can all be reached within a few dozen cycles. Counting each owed refresh through the handshake, with the bus first busy and then idle, checks that requests wait for idle, hold until acknowledged, and survive the timer being switched off.

// File: rtl/rfsh_pkg.sv
package rfsh_pkg;
  typedef struct packed {
    logic cntRun;
    logic cntWrap;
    logic toSet;
    logic push;
    logic pop;
    logic ovfSet;
  } rfshStrobes_t;
endpackage

// File: rtl/rfsh_datapath.sv
module rfsh_datapath
  import rfsh_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int QUEUE_DEPTH = 8
) (
  input  logic                               clk,
  input  logic                               rstN,
  input  rfshStrobes_t                       strobes,
  input  logic [CNT_W-1:0]                   cmpValue,
  input  logic                               clrTimeout,
  input  logic                               clrOverflow,
  output logic [CNT_W-1:0]                   count,
  output logic [$clog2(QUEUE_DEPTH+1)-1:0]   pending,
  output logic                               timeout,
  output logic                               overflow,
  output logic                               cntMatch,
  output logic                               pendFull,
  output logic                               pendZero
);
  localparam int PEND_W = $clog2(QUEUE_DEPTH + 1);
  localparam logic [PEND_W-1:0] PEND_MAX = PEND_W'(QUEUE_DEPTH);

  assign cntMatch = (count == cmpValue);
  assign pendFull = (pending == PEND_MAX);
  assign pendZero = (pending == '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      count <= '0;
    end else if (!strobes.cntRun || strobes.cntWrap) begin
      count <= '0;
    end else begin
      count <= count + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pending <= '0;
    end else begin
      unique case ({strobes.push, strobes.pop})
        2'b10:   pending <= pending + 1'b1;
        2'b01:   pending <= pending - 1'b1;
        default: pending <= pending;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      timeout  <= 1'b0;
      overflow <= 1'b0;
    end else begin
      if (strobes.toSet)    timeout <= 1'b1;
      else if (clrTimeout)  timeout <= 1'b0;
      if (strobes.ovfSet)   overflow <= 1'b1;
      else if (clrOverflow) overflow <= 1'b0;
    end
  end

  AST_PEND_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    pending <= PEND_MAX); // R6
  AST_CNT_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.cntRun |=> count == '0); // R2
  AST_TO_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    timeout && !clrTimeout |=> timeout); // R4
  AST_OVF_FROM_FULL: assert property (@(posedge clk) disable iff (!rstN)
    !overflow ##1 overflow |-> $past(pending) == PEND_MAX); // R7
endmodule

// File: rtl/rfsh_ctrl.sv
module rfsh_ctrl
  import rfsh_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         timerEn,
  input  logic         refreshEn,
  input  logic         cntMatch,
  input  logic         pendFull,
  input  logic         pendZero,
  input  logic         busIdle,
  input  logic         refreshAck,
  output rfshStrobes_t strobes,
  output logic         refreshReq
);
  logic expire;
  logic ackTaken;

  assign expire   = timerEn && cntMatch;
  assign ackTaken = refreshReq && refreshAck;

  always_comb begin
    strobes         = '0;
    strobes.cntRun  = timerEn;
    strobes.cntWrap = expire;
    strobes.toSet   = expire;
    strobes.pop     = ackTaken;
    strobes.push    = expire && refreshEn && (!pendFull || ackTaken);
    strobes.ovfSet  = expire && refreshEn && pendFull && !ackTaken;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      refreshReq <= 1'b0;
    end else if (refreshReq) begin
      if (refreshAck) refreshReq <= 1'b0;
    end else begin
      refreshReq <= !pendZero && busIdle;
    end
  end

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    refreshReq && !refreshAck |=> refreshReq); // R8
  AST_REQ_DROP: assert property (@(posedge clk) disable iff (!rstN)
    refreshReq && refreshAck |=> !refreshReq); // R8
  AST_REQ_OWED: assert property (@(posedge clk) disable iff (!rstN)
    refreshReq |-> !pendZero); // R6
  AST_REQ_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    !refreshReq && !busIdle |=> !refreshReq); // R8
endmodule

// File: rtl/rfsh_interval_timer.sv
module rfsh_interval_timer
  import rfsh_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int QUEUE_DEPTH = 8,
  parameter int NUM_CS      = 2
) (
  input  logic                              clk,
  input  logic                              rstN,
  input  logic                              timerEn,
  input  logic                              refreshEn,
  input  logic [CNT_W-1:0]                  cmpValue,
  input  logic                              clrTimeout,
  input  logic                              clrOverflow,
  input  logic                              busIdle,
  input  logic                              refreshAck,
  output logic [CNT_W-1:0]                  curCount,
  output logic                              timeoutIrq,
  output logic                              queueOverflow,
  output logic [$clog2(QUEUE_DEPTH+1)-1:0]  pendingCnt,
  output logic                              refreshReq,
  output logic [NUM_CS-1:0]                 refreshCs
);
  rfshStrobes_t strobes;
  logic cntMatch, pendFull, pendZero;

  rfsh_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .timerEn    (timerEn),
    .refreshEn  (refreshEn),
    .cntMatch   (cntMatch),
    .pendFull   (pendFull),
    .pendZero   (pendZero),
    .busIdle    (busIdle),
    .refreshAck (refreshAck),
    .strobes    (strobes),
    .refreshReq (refreshReq)
  );

  rfsh_datapath #(
    .CNT_W       (CNT_W),
    .QUEUE_DEPTH (QUEUE_DEPTH)
  ) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .strobes     (strobes),
    .cmpValue    (cmpValue),
    .clrTimeout  (clrTimeout),
    .clrOverflow (clrOverflow),
    .count       (curCount),
    .pending     (pendingCnt),
    .timeout     (timeoutIrq),
    .overflow    (queueOverflow),
    .cntMatch    (cntMatch),
    .pendFull    (pendFull),
    .pendZero    (pendZero)
  );

  for (genvar i = 0; i < NUM_CS; i++) begin : g_cs
    assign refreshCs[i] = refreshReq;
  end
endmodule

// File: tb/rfsh_interval_timer_tb.sv
module rfsh_interval_timer_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        timerEn = 0, refreshEn = 0, clrTimeout = 0, clrOverflow = 0;
  logic        busIdle = 0, refreshAck = 0;
  logic [15:0] cmpValue = '0;
  logic [15:0] curCount;
  logic        timeoutIrq, queueOverflow, refreshReq;
  logic [3:0]  pendingCnt;
  logic [1:0]  refreshCs;
  int checks = 0;
  int fails  = 0;

  always #2 clk = ~clk;

  rfsh_interval_timer u_dut (
    .clk(clk), .rstN(rstN), .timerEn(timerEn), .refreshEn(refreshEn),
    .cmpValue(cmpValue), .clrTimeout(clrTimeout), .clrOverflow(clrOverflow),
    .busIdle(busIdle), .refreshAck(refreshAck), .curCount(curCount),
    .timeoutIrq(timeoutIrq), .queueOverflow(queueOverflow),
    .pendingCnt(pendingCnt), .refreshReq(refreshReq), .refreshCs(refreshCs)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic edges(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic test_reset();
    check("R1 count", 32'(curCount), 0);
    check("R1 timeout", 32'(timeoutIrq), 0);
    check("R1 overflow", 32'(queueOverflow), 0);
    check("R1 pending", 32'(pendingCnt), 0);
    check("R1 req", 32'(refreshReq), 0);
  endtask

  task automatic test_timer_only();
    cmpValue = 16'd4; refreshEn = 0; timerEn = 1;
    edges(4);
    check("R2 count after 4", 32'(curCount), 4);
    check("R3 no early expiry", 32'(timeoutIrq), 0);
    edges(1);
    check("R3 wrap", 32'(curCount), 0);
    check("R4 timeout set", 32'(timeoutIrq), 1);
    check("R5 no pend", 32'(pendingCnt), 0);
    edges(5);
    check("R3 period", 32'(curCount), 0);
    check("R5 still no pend", 32'(pendingCnt), 0);
    timerEn = 0;
    edges(1);
    check("R2 held zero", 32'(curCount), 0);
    clrTimeout = 1; edges(1); clrTimeout = 0;
    check("R4 cleared", 32'(timeoutIrq), 0);
    edges(3);
    check("R2 no expiry when off", 32'(timeoutIrq), 0);
  endtask

  task automatic test_set_wins();
    cmpValue = 16'd0; timerEn = 1; clrTimeout = 1;
    edges(2);
    check("R4 set wins over clear", 32'(timeoutIrq), 1);
    timerEn = 0;
    edges(1);
    check("R4 clear after stop", 32'(timeoutIrq), 0);
    clrTimeout = 0;
  endtask

  task automatic test_overflow();
    cmpValue = 16'd1; refreshEn = 1; busIdle = 0; timerEn = 1;
    edges(16);
    check("R6 full", 32'(pendingCnt), 8);
    check("R7 no ovf yet", 32'(queueOverflow), 0);
    check("R8 no req while busy", 32'(refreshReq), 0);
    edges(2);
    check("R7 overflow", 32'(queueOverflow), 1);
    check("R7 dropped", 32'(pendingCnt), 8);
    timerEn = 0;
    clrOverflow = 1; edges(1); clrOverflow = 0;
    check("R7 cleared", 32'(queueOverflow), 0);
    edges(2);
    check("R10 pending kept", 32'(pendingCnt), 8);
  endtask

  task automatic drain(input int expected, input string tag);
    int issued = 0;
    busIdle = 1;
    for (int i = 0; i < 60; i++) begin
      @(negedge clk);
      if (refreshReq) begin
        check("R9 cs both", 32'(refreshCs), 32'h3);
        refreshAck = 1;
        issued++;
      end else begin
        check("R9 cs idle", 32'(refreshCs), 0);
        refreshAck = 0;
        if (pendingCnt == 0) break;
      end
    end
    refreshAck = 0;
    check(tag, issued, expected);
    check("R6 empty", 32'(pendingCnt), 0);
  endtask

  task automatic test_hold();
    cmpValue = 16'd0; refreshEn = 1; busIdle = 1; timerEn = 1;
    edges(1);
    timerEn = 0;
    edges(1);
    check("R8 req raised", 32'(refreshReq), 1);
    edges(3);
    check("R8 req held w/o ack", 32'(refreshReq), 1);
    refreshAck = 1; edges(1); refreshAck = 0;
    check("R8 req dropped", 32'(refreshReq), 0);
    check("R6 pop", 32'(pendingCnt), 0);
  endtask

  task automatic test_push_pop();
    cmpValue = 16'd0; refreshEn = 1; busIdle = 1; timerEn = 1;
    edges(2);
    check("R6 two owed", 32'(pendingCnt), 2);
    check("R8 req up", 32'(refreshReq), 1);
    refreshAck = 1;
    edges(1);
    refreshAck = 0; timerEn = 0;
    check("R6 push+pop same", 32'(pendingCnt), 2);
    check("R7 no ovf on push+pop", 32'(queueOverflow), 0);
    drain(2, "R10 drain count");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    edges(3);
    test_reset();
    rstN = 1;
    edges(1);
    test_reset();
    test_timer_only();
    test_set_wins();
    test_overflow();
    drain(8, "R10 eight issued after stop");
    test_hold();
    test_push_pop();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule